// File: doc/BRIEF.md
# One-Shot Biphase Line Decoder

This block takes a serial biphase line (Manchester level code, biphase-mark or biphase-space) and turns it into a stream of data bits, each accompanied by a one-cycle strobe. It runs entirely from an oversampling system clock. The half-bit time T is a parameter counted in system clock cycles. The line is first passed through a two-flop synchroniser. Every transition is then timed against a digital one-shot window 1.5T long. A transition that lands inside the window is a cell-edge transition and is ignored. The first transition after the window has closed restarts the window and is taken as the timing reference for a bit. A single sampled-level register and XOR logic produce the bit from it.

Before any bit is passed on, the decoder must acquire the line. It counts an unbroken run of 1T intervals, which a preamble of repeated symbols provides. After enough of them it raises a lock flag. If the line then stays quiet for 2.5T, the decoder reports a one-cycle violation and falls out of lock. When the window starts on the wrong phase, the first 2T interval on the line corrects it, so a frame is expected to carry one such interval between its preamble and its payload.

Top module: `obd_top`

## Requirements
- R1: The line input passes through two synchroniser flops before edge detection. A synchronous active-high reset clears `bit_o`, `valid_o`, `locked_o` and `violation_o` to 0.
- R2: An accepted transition opens a window of 1.5T. Any transition inside that window produces no strobe and does not restart the window. The first transition after the window restarts it.
- R3: With `code_i` = 0 (level code), each bit cell has a transition at its middle, where low-to-high means 1 and high-to-low means 0. The bit reported is the synchronised level just after that mid-cell transition. Code value 3 behaves like 0.
- R4: With `code_i` = 1 (mark code), the line toggles at every cell start. A further toggle at mid-cell means 1. The bit reported is the XOR of the level sampled just after the previous accepted transition and the level just before the current one.
- R5: With `code_i` = 2 (space code), the line toggles at every cell start. A further toggle at mid-cell means 0. The bit reported is the inverse of the XOR described in R4.
- R6: `locked_o` rises on the transition that completes 16 consecutive intervals each in the range [0.5T, 1.5T). While `locked_o` is 0, `valid_o` stays 0.
- R7: If no transition arrives for 2.5T while locked, `violation_o` pulses for exactly one cycle and `locked_o` falls to 0. No violation is reported while unlocked.
- R8: Transitions displaced by up to T/8 from their nominal times decode to the same bit stream.
- R9: `valid_o` is a single-cycle strobe that never stays high two cycles in a row. `bit_o` holds the decoded value in the cycle the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 cycles per half-bit |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 2 | Line code select: 0 level, 1 mark, 2 space, 3 as level |
| line_i | input | 1 | Asynchronous serial line |
| bit_o | output | 1 | Decoded bit, valid when `valid_o` is high |
| valid_o | output | 1 | One-cycle strobe per decoded bit |
| locked_o | output | 1 | Preamble acquired, bits are being passed |
| violation_o | output | 1 | One-cycle pulse when a locked line goes quiet for 2.5T |

## Verification
A window that reopens too early or too late puts the reference on cell edges. The result is wrong or doubled bits inside the very next byte of payload, so the checks look for each payload as one contiguous run in the received stream. A run counter that is off by one moves the rising edge of `locked_o` by one T. This is checked at the 15th and the 16th interval. A timeout counter that is off shows up as a violation inside the 2.5T quiet period, or as a missing one by 3.75T. Strobes without lock, or strobes two cycles long, are counted on every frame.

// File: rtl/obd_pkg.sv
package obd_pkg;

    typedef enum logic [1:0] {
        CODE_LEVEL = 2'd0,
        CODE_MARK  = 2'd1,
        CODE_SPACE = 2'd2,
        CODE_ALT   = 2'd3
    } line_code_e;

    typedef struct packed {
        logic data;
        logic strobe;
    } dec_out_t;

    function automatic int unsigned window_cycles(input int unsigned half_bit);
        return (3 * half_bit) / 2;
    endfunction

    function automatic int unsigned quiet_cycles(input int unsigned half_bit);
        return (5 * half_bit) / 2;
    endfunction

    // Bit value from the levels around the reference transition.
    function automatic logic pick_bit(input line_code_e code,
                                      input logic after_lvl,
                                      input logic before_lvl,
                                      input logic opened_lvl);
        case (code)
            CODE_MARK:  return opened_lvl ^ before_lvl;
            CODE_SPACE: return ~(opened_lvl ^ before_lvl);
            default:    return after_lvl;
        endcase
    endfunction

endpackage

// File: rtl/obd_sync.sv
module obd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic lvl_o,
    output logic prev_o,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;
    assign edge_o = lvl_o ^ prev_q;

endmodule

// File: rtl/obd_interval.sv
module obd_interval #(
    parameter int HALF_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    output logic accept_o,
    output logic short_o,
    output logic quiet_o
);
    localparam int unsigned WIN  = obd_pkg::window_cycles(HALF_BIT);
    localparam int unsigned TMO  = obd_pkg::quiet_cycles(HALF_BIT);
    localparam int unsigned HALF = HALF_BIT / 2;
    localparam int          CW   = $clog2(TMO + 1) + 1;

    logic [CW-1:0] since_edge_q;
    logic [CW-1:0] since_ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_edge_q <= CW'(TMO);
            since_ref_q  <= CW'(TMO);
        end else begin
            if (edge_i)
                since_edge_q <= CW'(1);
            else if (since_edge_q < CW'(TMO))
                since_edge_q <= since_edge_q + CW'(1);

            if (accept_o)
                since_ref_q <= CW'(1);
            else if (since_ref_q < CW'(TMO))
                since_ref_q <= since_ref_q + CW'(1);
        end
    end

    assign accept_o = edge_i && (since_ref_q >= CW'(WIN));
    assign short_o  = edge_i && (since_edge_q >= CW'(HALF)) && (since_edge_q < CW'(WIN));
    assign quiet_o  = !edge_i && (since_edge_q == CW'(TMO));

    // R7: a quiet report is never preceded directly by a transition
    a_r7_quiet_after_silence: assert property (@(posedge clk) disable iff (rst)
        quiet_o |-> !$past(edge_i));

    // R2: once accepted, the next cycle can not accept again
    a_r2_window_blocks: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> !accept_o);

endmodule

// File: rtl/obd_top.sv
module obd_top #(
    parameter int HALF_BIT = 8,
    parameter int LOCK_RUN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] code_i,
    input  logic       line_i,
    output logic       bit_o,
    output logic       valid_o,
    output logic       locked_o,
    output logic       violation_o
);
    import obd_pkg::*;

    localparam int RW = $clog2(LOCK_RUN + 1);

    logic lvl, prev, edge_seen;
    logic accept, short_gap, quiet;

    logic [RW-1:0] run_q;
    logic          locked_q;
    logic          viol_q;
    logic          opened_q;
    dec_out_t      dec_q;
    line_code_e    code;

    assign code = line_code_e'(code_i);

    obd_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .lvl_o  (lvl),
        .prev_o (prev),
        .edge_o (edge_seen)
    );

    obd_interval #(.HALF_BIT(HALF_BIT)) u_interval (
        .clk      (clk),
        .rst      (rst),
        .edge_i   (edge_seen),
        .accept_o (accept),
        .short_o  (short_gap),
        .quiet_o  (quiet)
    );

    // preamble acquisition and loss
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            locked_q <= 1'b0;
            viol_q   <= 1'b0;
        end else begin
            viol_q <= quiet && locked_q;
            if (quiet) begin
                locked_q <= 1'b0;
                run_q    <= '0;
            end else if (edge_seen) begin
                if (short_gap) begin
                    if (run_q != RW'(LOCK_RUN))
                        run_q <= run_q + RW'(1);
                    if (run_q == RW'(LOCK_RUN - 1))
                        locked_q <= 1'b1;
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

    // bit recovery: one level register plus XOR
    always_ff @(posedge clk) begin
        if (rst) begin
            opened_q <= 1'b0;
            dec_q    <= '0;
        end else begin
            dec_q.strobe <= 1'b0;
            if (accept) begin
                opened_q     <= lvl;
                dec_q.data   <= pick_bit(code, lvl, prev, opened_q);
                dec_q.strobe <= locked_q;
            end
        end
    end

    assign bit_o       = dec_q.data;
    assign valid_o     = dec_q.strobe;
    assign locked_o    = locked_q;
    assign violation_o = viol_q;

    // R9: strobe lasts one cycle
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6: no bit leaves while unlocked
    a_r6_strobe_needs_lock: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> locked_o);

    // R6: lock is only gained on a transition
    a_r6_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(edge_seen));

    // R7: a violation leaves the block unlocked
    a_r7_violation_unlocks: assert property (@(posedge clk) disable iff (rst)
        violation_o |-> !locked_o);

    // R7: violations only come from a locked state
    a_r7_violation_was_locked: assert property (@(posedge clk) disable iff (rst)
        violation_o |-> $past(locked_o));

endmodule

// File: tb/tb_obd_top.sv
`timescale 1ns/1ps
module tb_obd_top;
    import obd_pkg::*;

    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] code_i = 2'd0;
    logic       line_i = 1'b0;
    logic       bit_o, valid_o, locked_o, violation_o;

    int checks = 0;
    int fails  = 0;

    logic rx [0:255];
    int   rx_n = 0;
    int   strobes_unlocked = 0;
    int   strobes_double = 0;
    int   viol_n = 0;
    logic prev_v = 1'b0;

    always #10 clk = ~clk;

    obd_top #(.HALF_BIT(T), .LOCK_RUN(16)) dut (
        .clk(clk), .rst(rst), .code_i(code_i), .line_i(line_i),
        .bit_o(bit_o), .valid_o(valid_o), .locked_o(locked_o),
        .violation_o(violation_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                if (rx_n < 256) rx[rx_n] = bit_o;
                rx_n = rx_n + 1;
                if (!locked_o) strobes_unlocked = strobes_unlocked + 1;
                if (prev_v) strobes_double = strobes_double + 1;
            end
            if (violation_o) viol_n = viol_n + 1;
            prev_v = valid_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] code);
        rst    = 1'b1;
        line_i = 1'b0;
        code_i = code;
        hold(5);
        rst    = 1'b0;
        rx_n   = 0;
        strobes_unlocked = 0;
        strobes_double   = 0;
        viol_n = 0;
        prev_v = 1'b0;
        hold(3);
    endtask

    function automatic bit payload_found(input logic [15:0] p);
        for (int off = 0; off + 16 <= rx_n && off + 16 <= 256; off++) begin
            bit same = 1'b1;
            for (int k = 0; k < 16; k++)
                if (rx[off+k] !== p[15-k]) same = 1'b0;
            if (same) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Encode one bit with optional per-bit displacement of one cycle
    task automatic send_bit(input line_code_e code, input logic b, input int j);
        case (code)
            CODE_MARK: begin
                line_i = ~line_i; hold(T + j);
                if (b) line_i = ~line_i;
                hold(T - j);
            end
            CODE_SPACE: begin
                line_i = ~line_i; hold(T + j);
                if (!b) line_i = ~line_i;
                hold(T - j);
            end
            default: begin
                line_i = ~b; hold(T + j);
                line_i = b;  hold(T - j);
            end
        endcase
    endtask

    // preamble of 20 symbols, one phase-fixing bit, payload, two trailing symbols
    task automatic send_frame(input line_code_e code, input logic [15:0] payload, input bit jit);
        logic pre;
        int   idx = 0;
        pre = (code == CODE_MARK) ? 1'b1 : 1'b0;
        for (int i = 0; i < 20; i++) begin
            send_bit(code, pre, jit ? (idx % 3) - 1 : 0); idx++;
        end
        send_bit(code, ~pre, jit ? (idx % 3) - 1 : 0); idx++;
        for (int i = 15; i >= 0; i--) begin
            send_bit(code, payload[i], jit ? (idx % 3) - 1 : 0); idx++;
        end
        for (int i = 0; i < 2; i++) begin
            send_bit(code, pre, 0); idx++;
        end
        hold(6 * T);
    endtask

    task automatic t_reset;
        rst = 1'b1; line_i = 1'b0;
        hold(5);
        check(bit_o == 1'b0, "R1 reset bit_o", int'(bit_o), 0);
        check(valid_o == 1'b0, "R1 reset valid_o", int'(valid_o), 0);
        check(locked_o == 1'b0 && violation_o == 1'b0, "R1 reset flags",
              int'({locked_o, violation_o}), 0);
        rst = 1'b0;
    endtask

    task automatic t_lock_and_quiet;
        int v0;
        do_reset(2'd0);
        line_i = ~line_i;                       // first transition, no interval yet
        for (int e = 1; e <= 15; e++) begin
            hold(T); line_i = ~line_i;
        end
        hold(4);
        check(locked_o == 1'b0, "R6 unlocked after 15 intervals", int'(locked_o), 0);
        check(rx_n == 0, "R6 no strobe before lock", rx_n, 0);
        hold(T - 4); line_i = ~line_i;          // 16th interval
        hold(5);
        check(locked_o == 1'b1, "R6 locked after 16 intervals", int'(locked_o), 1);
        v0 = viol_n;
        hold(11);                               // 16 cycles since last change
        check(locked_o == 1'b1 && viol_n == v0, "R7 no violation inside 2.5T",
              viol_n - v0, 0);
        hold(14);                               // 30 cycles since last change
        check(locked_o == 1'b0, "R7 lock dropped after quiet", int'(locked_o), 0);
        check(viol_n == v0 + 1, "R7 single violation pulse", viol_n - v0, 1);
    endtask

    task automatic t_frame(input line_code_e code, input logic [15:0] p, input bit jit, input string req);
        do_reset(code);
        send_frame(code, p, jit);
        check(payload_found(p), req, rx_n, 16);
        check(strobes_unlocked == 0 && strobes_double == 0,
              "R9 R6 strobe shape", strobes_unlocked + strobes_double, 0);
        check(viol_n == 1 && locked_o == 1'b0, "R7 violation after frame end", viol_n, 1);
    endtask

    task automatic t_alt_code;
        do_reset(2'd3);
        send_frame(CODE_LEVEL, 16'h3C96, 1'b0);
        check(payload_found(16'h3C96), "R3 code 3 decodes as level", rx_n, 16);
    endtask

    initial begin
        t_reset();
        t_lock_and_quiet();
        t_frame(CODE_LEVEL, 16'hA5C3, 1'b0, "R3 R2 level code payload");
        t_frame(CODE_LEVEL, 16'hFFFF, 1'b0, "R2 R3 level all ones, cell edges ignored");
        t_frame(CODE_LEVEL, 16'h0000, 1'b0, "R2 R3 level all zeros");
        t_frame(CODE_MARK,  16'hA5C3, 1'b0, "R4 mark code payload");
        t_frame(CODE_MARK,  16'h1E2D, 1'b0, "R4 mark code second pattern");
        t_frame(CODE_SPACE, 16'hA5C3, 1'b0, "R5 space code payload");
        t_frame(CODE_SPACE, 16'hF00F, 1'b0, "R5 space code second pattern");
        t_frame(CODE_LEVEL, 16'h6B1D, 1'b1, "R8 level code displaced edges");
        t_frame(CODE_MARK,  16'h6B1D, 1'b1, "R8 mark code displaced edges");
        t_alt_code();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule